// File: doc/BRIEF.md
# I2C SCL Bit-Rate Generator

This block sets the bit rate of an I2C master. Software stores a 7-bit rate code. The upper four bits form a multiplier term M and the lower three bits form an exponent term N. A first counter divides the system clock by (M+1)·2^(N+1) and produces a one-cycle tick. A second counter takes ten ticks to make one SCL period. SCL is high for the first five ticks of the period and low for the last five.

The bus engine receives a one-cycle strobe at four points in each period. It uses these strobes to place its SDA changes and its sampling. The stored code can be read back at all times. A new code never cuts short the period in progress: the counters use it only from the next period boundary. A soft reset returns the code to its power-up value. While the controller is disabled, both counters stay at zero.

Top module: `scl_rate_gen`

## Requirements
- R1: After the synchronous active-low reset, `baud_field` reads 0x44, `scl_level` is 1 and `quarter_stb` is 0.
- R2: The code holds M in bits 6:3 and N in bits 2:0. With L = (M+1)·2^(N+1) system clocks per tick, one SCL period lasts 10·L clocks. The power-up code 0x44 (M=8, N=4) gives L = 288.
- R3: Within each period, `scl_level` is high for exactly 5·L clocks, then low for exactly 5·L clocks.
- R4: `quarter_stb` gives four one-cycle pulses per period, spaced 2L, 3L, 2L, 3L clocks apart. Two pulses are never adjacent. `scl_level` changes only in the cycle after a pulse (or after a soft reset or disable).
- R5: When `baud_wr` is high in a cycle, `baud_wdata` is visible on `baud_field` in the next cycle.
- R6: A code written during a period does not change the rest of that period. It takes effect from the next SCL rising edge, which is the next period boundary.
- R7: A `soft_rst` pulse sets `baud_field` back to 0x44 and restarts the period with SCL high. If a write falls in the same cycle, the soft reset wins.
- R8: While `enable` is 0, both counters stay at zero, `scl_level` stays 1 and `quarter_stb` stays 0. When `enable` returns to 1, the stored code applies at once: SCL stays high for 5·L clocks, counted from the cycle in which `enable` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| soft_rst | input | 1 | Controller soft reset pulse |
| enable | input | 1 | Controller enabled; when low, the counters stay at zero |
| baud_wr | input | 1 | Write strobe for the rate code |
| baud_wdata | input | 7 | Rate code to store: M in bits 6:3, N in bits 2:0 |
| baud_field | output | 7 | Stored rate code |
| scl_level | output | 1 | SCL level the bus engine should drive |
| quarter_stb | output | 1 | One-cycle pulse at each quarter point of the SCL period |

## Verification
The assertions are checked on every cycle. They cover the following:
- the code shown after a write or a soft reset;
- that strobes never fall on adjacent cycles;
- that SCL never moves without a preceding strobe, soft reset or disable;
- that the active code stays fixed between period boundaries;
- that the generator is quiet while disabled.

Some behaviour only the bench scenarios can show, because it depends on counting clocks over whole periods. This includes the high and low lengths for several M/N codes, the 2L/3L strobe spacing, the old low phase that follows a write made mid-period, and the 5·L first high phase after re-enable or soft reset.

// File: rtl/scl_rate_pkg.sv
// Package: shared defaults and the prescale-length formula of the SCL generator.
// Assumes: M is a multiplier term and N an exponent term; the result fits in 32 bits.
package scl_rate_pkg;

    localparam int unsigned DEF_M_W    = 4;
    localparam int unsigned DEF_N_W    = 3;
    localparam int unsigned DEF_PHASES = 10;
    localparam logic [6:0]  DEF_BAUD   = 7'h44;

    // Clocks per tick for a given M and N: (M+1) * 2^(N+1).
    function automatic int unsigned tick_len(input int unsigned m, input int unsigned n);
        return (m + 1) << (n + 1);
    endfunction

endpackage

// File: rtl/scl_baud_store.sv
// Module: holds the software-visible rate code and the copy the counters use.
// Assumes: period_end is a one-cycle pulse at the last tick of a period;
//          the active copy follows the stored code at every cycle while disabled.
module scl_baud_store #(
    parameter int unsigned           FIELD_W = 7,
    parameter logic [FIELD_W-1:0]    RST_VAL = 7'h44
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               soft_rst,
    input  logic               enable,
    input  logic               period_end,
    input  logic               wr,
    input  logic [FIELD_W-1:0] wdata,
    output logic [FIELD_W-1:0] field_o,
    output logic [FIELD_W-1:0] active_o
);

    logic [FIELD_W-1:0] field_q;
    logic [FIELD_W-1:0] active_q;

    // Stored code: reset and soft reset restore the default; otherwise a write replaces it.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            field_q <= RST_VAL;
        end else if (wr) begin
            field_q <= wdata;
        end
    end

    // Active code: reloads only at a period boundary, or at every cycle while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            active_q <= RST_VAL;
        end else if (!enable || period_end) begin
            active_q <= field_q;
        end
    end

    assign field_o  = field_q;
    assign active_o = active_q;

endmodule

// File: rtl/scl_prescaler.sv
// Module: first divider stage; emits a one-cycle tick every (M+1)*2^(N+1) clocks.
// Assumes: m and n stay stable between ticks (they come from the active copy).
module scl_prescaler #(
    parameter int unsigned M_W = 4,
    parameter int unsigned N_W = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           enable,
    input  logic [M_W-1:0] m,
    input  logic [N_W-1:0] n,
    output logic           tick
);

    localparam int unsigned CNT_W = M_W + (1 << N_W);

    logic [CNT_W:0]   len;
    logic [CNT_W:0]   limit;
    logic [CNT_W-1:0] cnt_q;
    logic             at_limit;

    // Length and terminal count from M and N.
    always_comb begin
        len   = ({{(CNT_W + 1 - M_W){1'b0}}, m} + 1'b1) << ({1'b0, n} + 1'b1);
        limit = len - 1'b1;
    end

    assign at_limit = ({1'b0, cnt_q} == limit);
    assign tick     = enable && at_limit;

    // Prescale counter: held at zero when disabled or cleared, wraps at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || !enable) begin
            cnt_q <= '0;
        end else if (at_limit) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/scl_phase_seq.sv
// Module: second divider stage; counts PHASES ticks per SCL period.
// SCL is high during the first half of the period. Strobes mark the quarter points.
// Assumes: PHASES is even and at least 4; ticks are never on adjacent cycles.
module scl_phase_seq #(
    parameter int unsigned PHASES = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic enable,
    input  logic tick,
    output logic scl_o,
    output logic quarter_o,
    output logic period_end_o
);

    localparam int unsigned PH_W = $clog2(PHASES);
    localparam int unsigned HALF = PHASES / 2;
    localparam int unsigned QTR  = HALF / 2;
    localparam int unsigned SLOTS = 1 << PH_W;

    logic [PH_W-1:0]  phase_q;
    logic [PH_W-1:0]  phase_nxt;
    logic             last_phase;
    logic [SLOTS-1:0] qmark;

    // Quarter-point marks: start of each half and QTR ticks into each half.
    for (genvar p = 0; p < SLOTS; p++) begin : g_qmark
        if (p == 0 || p == QTR || p == HALF || p == HALF + QTR) begin : g_on
            assign qmark[p] = 1'b1;
        end else begin : g_off
            assign qmark[p] = 1'b0;
        end
    end

    assign last_phase = (phase_q == PH_W'(PHASES - 1));
    assign phase_nxt  = last_phase ? '0 : phase_q + 1'b1;

    // Phase counter: held at zero when disabled or cleared, advanced by ticks.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || !enable) begin
            phase_q <= '0;
        end else if (tick) begin
            phase_q <= phase_nxt;
        end
    end

    assign scl_o        = (phase_q < PH_W'(HALF));
    assign quarter_o    = tick && qmark[phase_nxt];
    assign period_end_o = tick && last_phase;

endmodule

// File: rtl/scl_rate_gen.sv
// Module: top of the I2C SCL bit-rate generator.
// The rate code carries M in the upper M_W bits and N in the lower N_W bits.
// Assumes: soft_rst is synchronous; enable comes from the controller's enable bit.
module scl_rate_gen
    import scl_rate_pkg::*;
#(
    parameter int unsigned               M_W      = DEF_M_W,
    parameter int unsigned               N_W      = DEF_N_W,
    parameter int unsigned               PHASES   = DEF_PHASES,
    parameter logic [M_W+N_W-1:0]        RST_BAUD = DEF_BAUD
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               soft_rst,
    input  logic               enable,
    input  logic               baud_wr,
    input  logic [M_W+N_W-1:0] baud_wdata,
    output logic [M_W+N_W-1:0] baud_field,
    output logic               scl_level,
    output logic               quarter_stb
);

    localparam int unsigned FIELD_W = M_W + N_W;

    logic [FIELD_W-1:0] act_field;
    logic               tick;
    logic               period_end;

    scl_baud_store #(
        .FIELD_W (FIELD_W),
        .RST_VAL (RST_BAUD)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst   (soft_rst),
        .enable     (enable),
        .period_end (period_end),
        .wr         (baud_wr),
        .wdata      (baud_wdata),
        .field_o    (baud_field),
        .active_o   (act_field)
    );

    scl_prescaler #(
        .M_W (M_W),
        .N_W (N_W)
    ) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (soft_rst),
        .enable (enable),
        .m      (act_field[FIELD_W-1:N_W]),
        .n      (act_field[N_W-1:0]),
        .tick   (tick)
    );

    scl_phase_seq #(
        .PHASES (PHASES)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr          (soft_rst),
        .enable       (enable),
        .tick         (tick),
        .scl_o        (scl_level),
        .quarter_o    (quarter_stb),
        .period_end_o (period_end)
    );

endmodule

// File: rtl/scl_rate_gen_chk.sv
// Checker: cycle-level properties of the SCL generator. It is bound into scl_rate_gen.
// Assumes: synchronous active-low reset; soft_rst and enable are sampled on clk.
module scl_rate_gen_chk #(
    parameter int unsigned            FIELD_W  = 7,
    parameter logic [FIELD_W-1:0]     RST_BAUD = 7'h44
) (
    input logic               clk,
    input logic               rst_n,
    input logic               soft_rst,
    input logic               enable,
    input logic               baud_wr,
    input logic [FIELD_W-1:0] baud_wdata,
    input logic [FIELD_W-1:0] baud_field,
    input logic               scl_level,
    input logic               quarter_stb,
    input logic [FIELD_W-1:0] act_field,
    input logic               period_end
);

    logic valid_q;
    logic scl_q;
    logic stb_q;
    logic force_q;

    // History of the previous cycle, used by the SCL-movement property.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            scl_q   <= 1'b1;
            stb_q   <= 1'b0;
            force_q <= 1'b0;
        end else begin
            valid_q <= 1'b1;
            scl_q   <= scl_level;
            stb_q   <= quarter_stb;
            force_q <= soft_rst || !enable;
        end
    end

    a_r7_soft_default: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (baud_field == RST_BAUD));

    a_r5_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
        (baud_wr && !soft_rst) |=> (baud_field == $past(baud_wdata)));

    a_r4_no_adjacent_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        quarter_stb |=> !quarter_stb);

    a_r4_scl_moves_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && !stb_q && !force_q) |-> (scl_level == scl_q));

    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> !quarter_stb);

    a_r8_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> scl_level);

    a_r6_code_held_mid_period: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !soft_rst && !period_end) |=> $stable(act_field));

endmodule

bind scl_rate_gen scl_rate_gen_chk #(
    .FIELD_W  (FIELD_W),
    .RST_BAUD (RST_BAUD)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .soft_rst    (soft_rst),
    .enable      (enable),
    .baud_wr     (baud_wr),
    .baud_wdata  (baud_wdata),
    .baud_field  (baud_field),
    .scl_level   (scl_level),
    .quarter_stb (quarter_stb),
    .act_field   (act_field),
    .period_end  (period_end)
);

// File: tb/scl_rate_gen_test.sv
// Directed bench for scl_rate_gen. Inputs are driven and outputs sampled on the falling edge.
module scl_rate_gen_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       soft_rst = 1'b0;
    logic       enable = 1'b0;
    logic       baud_wr = 1'b0;
    logic [6:0] baud_wdata = '0;
    logic [6:0] baud_field;
    logic       scl_level;
    logic       quarter_stb;

    int n_checks = 0;
    int n_errors = 0;

    always #5 clk = ~clk;

    scl_rate_gen uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .soft_rst    (soft_rst),
        .enable      (enable),
        .baud_wr     (baud_wr),
        .baud_wdata  (baud_wdata),
        .baud_field  (baud_field),
        .scl_level   (scl_level),
        .quarter_stb (quarter_stb)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Clocks per tick, from the field layout of R2.
    function automatic int tick_of(input logic [6:0] code);
        return (int'(code[6:3]) + 1) << (int'(code[2:0]) + 1);
    endfunction

    task automatic wr_baud(input logic [6:0] v);
        baud_wdata = v;
        baud_wr    = 1'b1;
        @(negedge clk);
        baud_wr    = 1'b0;
    endtask

    // Stops at the first falling-edge sample after SCL has gone from low to high.
    task automatic sync_rise();
        do @(negedge clk); while (scl_level !== 1'b0);
        do @(negedge clk); while (scl_level !== 1'b1);
    endtask

    // Counts the samples that keep the current level; returns at the first sample of the other level.
    task automatic run_len(output int n);
        logic lv;
        lv = scl_level;
        n  = 0;
        while (scl_level === lv) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(baud_field == 7'h44, "R1 reset code", baud_field, 'h44);
        check(scl_level == 1'b1, "R1 reset scl", scl_level, 1);
        check(quarter_stb == 1'b0, "R1 reset strobe", quarter_stb, 0);
    endtask

    task automatic t_default();
        int h, l;
        enable = 1'b1;
        run_len(h);
        run_len(l);
        check(h == 1440, "R2 default high", h, 1440);
        check(l == 1440, "R3 default low", l, 1440);
    endtask

    task automatic t_rates();
        logic [6:0] codes [4] = '{7'h00, 7'h19, 7'h78, 7'h01};
        foreach (codes[i]) begin
            int h, l, len;
            len = tick_of(codes[i]);
            wr_baud(codes[i]);
            check(baud_field == codes[i], "R5 code readback", baud_field, codes[i]);
            sync_rise();
            run_len(h);
            run_len(l);
            check(h == 5 * len, "R2 high length", h, 5 * len);
            check(l == 5 * len, "R3 low length", l, 5 * len);
        end
    endtask

    task automatic t_quarter();
        int times [5];
        int k, t;
        wr_baud(7'h00);
        sync_rise();
        k = 0;
        t = 0;
        while (k < 5) begin
            if (quarter_stb === 1'b1) begin
                times[k] = t;
                k++;
            end
            t++;
            @(negedge clk);
        end
        for (int i = 0; i < 4; i++) begin
            int g;
            g = times[i+1] - times[i];
            check(g == 4 || g == 6, "R4 strobe gap", g, 4);
        end
        check((times[2] - times[0]) + 0 == 10 || (times[2] - times[0]) == 10, "R4 strobe pairs",
              times[2] - times[0], 10);
        check(times[4] - times[0] == 20, "R4 four per period", times[4] - times[0], 20);
    endtask

    task automatic t_midchange();
        int h, l;
        sync_rise();
        wr_baud(7'h08);
        run_len(h);
        run_len(l);
        check(h == 9, "R6 old high kept", h, 9);
        check(l == 10, "R6 old low kept", l, 10);
        run_len(h);
        run_len(l);
        check(h == 20, "R6 new high", h, 20);
        check(l == 20, "R6 new low", l, 20);
    endtask

    task automatic t_soft();
        int h;
        @(negedge clk);
        soft_rst   = 1'b1;
        baud_wr    = 1'b1;
        baud_wdata = 7'h00;
        @(negedge clk);
        soft_rst   = 1'b0;
        baud_wr    = 1'b0;
        check(baud_field == 7'h44, "R7 soft reset beats write", baud_field, 'h44);
        run_len(h);
        check(h == 1440, "R7 restart high", h, 1440);
    endtask

    task automatic t_disable();
        int bad, h, l;
        wr_baud(7'h00);
        sync_rise();
        enable = 1'b0;
        @(negedge clk);
        bad = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (scl_level !== 1'b1 || quarter_stb !== 1'b0) bad++;
        end
        check(bad == 0, "R8 idle high and quiet", bad, 0);
        wr_baud(7'h10);
        check(baud_field == 7'h10, "R8 write while idle", baud_field, 'h10);
        repeat (3) @(negedge clk);
        enable = 1'b1;
        run_len(h);
        run_len(l);
        check(h == 30, "R8 first high after enable", h, 30);
        check(l == 30, "R8 first low after enable", l, 30);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_default();
        t_rates();
        t_quarter();
        t_midchange();
        t_soft();
        t_disable();
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule